// File: doc/BRIEF.md
# Indirect Transfer Buffer Controller

This block sits between a host word port, a software configuration port and a flash transfer engine. It owns an on-chip byte buffer that is split into a read partition and a write partition. For an indirect read, software programs a flash start address and a byte count, then sets the start bit. The engine streams bytes into the read partition, and the host drains them through a data window, one 32-bit word or one byte at a time. For an indirect write, the host fills the write partition through the same window, and the engine drains it one byte at a time.

Each direction is run by a three-state machine. The states are `XF_IDLE`, `XF_BUSY` and `XF_DONE`. The transitions are:
- launch: from `XF_IDLE` or `XF_DONE` to `XF_BUSY` on a start with a non-zero count.
- empty launch: from `XF_IDLE` or `XF_DONE` to `XF_DONE` on a start with a zero count.
- finish: from `XF_BUSY` to `XF_DONE` when the engine moves the last byte.
- abort: from `XF_BUSY` to `XF_IDLE` on a cancel.
- acknowledge: from `XF_DONE` to `XF_IDLE` when software writes 1 to the done bit.

A remaining-byte counter per direction drives completion. Fill levels are reported in 32-bit words, rounded up.

The host window stalls by holding `host_ack` low: on a read when too few bytes are buffered, and on a write when the side is not busy, no bytes are owed or the partition lacks room. The engine sees a plain byte stream with valid/ready handshakes.

Top module: `ixb_buffer_ctrl`

## Requirements
- R1: After reset, both control registers read 0, the level register reads 0, the split register reads DEPTH_WORDS/2, and `eng_rd_ready` and `eng_wr_valid` are low.
- R2: Both control registers use the same fields: bit 0 is start, bit 1 is cancel, bit 2 is in-progress (read-only) and bit 5 is done. A start accepted in `XF_IDLE` or `XF_DONE` sets in-progress on the next clock and empties that side's buffer. A start written while in-progress is ignored.
- R3: Read bytes leave in arrival order. A word read (`host_word`=1) returns the four oldest bytes, with the oldest in bits 7:0. A byte read returns the oldest byte in bits 7:0, with zeros above it.
- R4: A host word read is acknowledged only when at least 4 bytes are buffered, and a byte read only when at least 1 is. `eng_rd_ready` is high only while the read side is busy and its partition has room.
- R5: `eng_*_left` loads the count on start and drops by one for each byte the engine moves. On the clock that moves the last byte, done sets and in-progress clears together. A start with a zero count goes straight to done.
- R6: Writing 1 to bit 5 of a control register clears done. Writing 0 there leaves done set.
- R7: A cancel while in-progress clears in-progress on the next clock, leaves done clear and empties that side's buffer. A cancel while not in-progress has no effect.
- R8: A host write is acknowledged only while the write side is busy, bytes are still owed and the partition has room. A word write stores bits 7:0 first. When fewer than 4 bytes are owed, a word write stores only those low bytes.
- R9: A write transfer reaches done with the write fill level at zero, once every programmed byte has left through `eng_wr_*`.
- R10: The level register (index 6) holds the read fill in bits 15:0 and the write fill in bits 31:16, each counted as ceil(bytes/4) words.
- R11: The split register (index 7) gives the read partition size in words; the write side gets the rest. A write of 1 to DEPTH_WORDS-1 while neither side is busy is taken and empties both buffers. Any other split write is ignored.
- R12: Register map: index 0 is read control, 1 read address, 2 read count, 3 write control, 4 write address, 5 write count. The address and count registers read back as written, and the addresses appear on `eng_rd_addr` and `eng_wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| host_req | input | 1 | Host data window request |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_ack | output | 1 | Access taken this cycle; low means stall |
| eng_rd_valid | input | 1 | Engine offers a read byte |
| eng_rd_byte | input | 8 | Read byte from flash |
| eng_rd_ready | output | 1 | Read partition accepts a byte |
| eng_rd_busy | output | 1 | Read transfer in progress |
| eng_rd_addr | output | ADDR_W | Read flash start address |
| eng_rd_left | output | LEN_W | Read bytes still to come |
| eng_wr_ready | input | 1 | Engine takes a write byte |
| eng_wr_valid | output | 1 | Write byte available |
| eng_wr_byte | output | 8 | Next write byte |
| eng_wr_busy | output | 1 | Write transfer in progress |
| eng_wr_addr | output | ADDR_W | Write flash start address |
| eng_wr_left | output | LEN_W | Write bytes still to send |

## Verification
The bench covers the following corner cases:
- A read tail of 6 bytes, where a word read must stall with 3 bytes buffered and a byte read must pop exactly one. A design that popped a whole word would lose bytes.
- A full read partition, where a leaky design would overwrite unread data.
- A last word write that must be cut to the 2 bytes still owed. A design that pushed all four would leave the write level above zero at done.
- Start while busy, cancel while idle, and split writes while busy or out of range. Here a faulty design would restart counters or corrupt the pointers of a live transfer.
- Done and in-progress must change on the same clock.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_BUSY = 2'd1,
        XF_DONE = 2'd2
    } xfer_state_e;

    // control register field positions (shared by both directions)
    localparam int CTL_START  = 0;
    localparam int CTL_CANCEL = 1;
    localparam int CTL_BUSY   = 2;
    localparam int CTL_DONE   = 5;

    // configuration register indices
    localparam logic [2:0] RA_RD_CTL  = 3'd0;
    localparam logic [2:0] RA_RD_ADDR = 3'd1;
    localparam logic [2:0] RA_RD_LEN  = 3'd2;
    localparam logic [2:0] RA_WR_CTL  = 3'd3;
    localparam logic [2:0] RA_WR_ADDR = 3'd4;
    localparam logic [2:0] RA_WR_LEN  = 3'd5;
    localparam logic [2:0] RA_LEVEL   = 3'd6;
    localparam logic [2:0] RA_SPLIT   = 3'd7;

endpackage

// File: rtl/ixb_ring.sv
module ixb_ring #(
    parameter int SPAN  = 64,
    parameter int LANES = 4,
    parameter int CW    = $clog2(SPAN + 1),
    parameter int LW    = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] size,
    input  logic [LW-1:0] push_n,
    input  logic [LW-1:0] pop_n,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] space,
    output logic [CW-1:0] wr_lane [LANES],
    output logic [CW-1:0] rd_lane [LANES]
);

    logic [CW-1:0] wptr_q;
    logic [CW-1:0] rptr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [CW-1:0] wrap(input logic [CW:0] x, input logic [CW-1:0] sz);
        logic [CW:0] szx;
        szx = {1'b0, sz};
        return (x >= szx) ? CW'(x - szx) : CW'(x);
    endfunction

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            wr_lane[i] = wrap({1'b0, wptr_q} + (CW+1)'(i), size);
            rd_lane[i] = wrap({1'b0, rptr_q} + (CW+1)'(i), size);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            wptr_q <= wrap({1'b0, wptr_q} + (CW+1)'(push_n), size);
            rptr_q <= wrap({1'b0, rptr_q} + (CW+1)'(pop_n), size);
            cnt_q  <= cnt_q + CW'(push_n) - CW'(pop_n);
        end
    end

    assign cnt   = cnt_q;
    assign space = size - cnt_q;

endmodule

// File: rtl/ixb_xfer_fsm.sv
module ixb_xfer_fsm
    import ixb_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cancel_req,
    input  logic             done_clr,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic             busy,
    output logic             done,
    output logic             launch,
    output logic             abort,
    output logic [LEN_W-1:0] left
);

    xfer_state_e state_q, state_d;
    logic [LEN_W-1:0] left_q;
    logic len_zero;

    assign len_zero = (len_in == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: begin
                if (start_req) state_d = len_zero ? XF_DONE : XF_BUSY;
            end
            XF_BUSY: begin
                if (cancel_req)                             state_d = XF_IDLE;
                else if (step && left_q == LEN_W'(1))       state_d = XF_DONE;
            end
            XF_DONE: begin
                if (start_req)     state_d = len_zero ? XF_DONE : XF_BUSY;
                else if (done_clr) state_d = XF_IDLE;
            end
            default: state_d = XF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state_q == XF_BUSY);
        done   = (state_q == XF_DONE);
        launch = start_req && (state_q != XF_BUSY);
        abort  = cancel_req && (state_q == XF_BUSY);
    end

    // remaining-byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               left_q <= '0;
        else if (launch)          left_q <= len_in;
        else if (abort)           left_q <= '0;
        else if (busy && step)    left_q <= left_q - LEN_W'(1);
    end

    assign left = left_q;

endmodule

// File: rtl/ixb_buffer_ctrl.sv
module ixb_buffer_ctrl
    import ixb_pkg::*;
#(
    parameter int DEPTH_WORDS = 16,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_word,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ack,
    input  logic              eng_rd_valid,
    input  logic [7:0]        eng_rd_byte,
    output logic              eng_rd_ready,
    output logic              eng_rd_busy,
    output logic [ADDR_W-1:0] eng_rd_addr,
    output logic [LEN_W-1:0]  eng_rd_left,
    input  logic              eng_wr_ready,
    output logic              eng_wr_valid,
    output logic [7:0]        eng_wr_byte,
    output logic              eng_wr_busy,
    output logic [ADDR_W-1:0] eng_wr_addr,
    output logic [LEN_W-1:0]  eng_wr_left
);

    localparam int NB    = DEPTH_WORDS * 4;
    localparam int CW    = $clog2(NB + 1);
    localparam int BAW   = $clog2(NB);
    localparam int PW    = $clog2(DEPTH_WORDS + 1);
    localparam int LANES = 4;
    localparam int LW    = $clog2(LANES + 1);

    // configuration state
    logic [PW-1:0]     split_q;
    logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
    logic [LEN_W-1:0]  rd_len_q, wr_len_q, host_left_q;

    // control decode
    logic rd_ctl_we, wr_ctl_we, split_ok;
    logic rd_busy, rd_done, rd_launch, rd_abort;
    logic wr_busy, wr_done, wr_launch, wr_abort;
    logic rd_flush, wr_flush;

    // buffer bookkeeping
    logic [CW-1:0] rd_size, wr_size, rd_cnt, wr_cnt, rd_space, wr_space;
    logic [CW-1:0] rd_wl [LANES];
    logic [CW-1:0] rd_rl [LANES];
    logic [CW-1:0] wr_wl [LANES];
    logic [CW-1:0] wr_rl [LANES];
    logic [CW-1:0] wr_wa [LANES];
    logic [CW-1:0] wr_ra;
    logic [7:0]    rd_b  [LANES];
    logic [LW-1:0] rd_push_n, rd_pop_n, wr_push_n, wr_pop_n, wr_req_n;
    logic          rd_ok, wr_ok, rd_push, wr_pop;
    logic [CW:0]   rd_lvl_w, wr_lvl_w;

    logic [7:0] mem [NB];

    // ------------------------------------------------------------------
    // configuration decode
    // ------------------------------------------------------------------
    assign rd_ctl_we = cfg_we && (cfg_addr == RA_RD_CTL);
    assign wr_ctl_we = cfg_we && (cfg_addr == RA_WR_CTL);
    assign split_ok  = cfg_we && (cfg_addr == RA_SPLIT) && !rd_busy && !wr_busy &&
                       (cfg_wdata != 32'd0) && (cfg_wdata < 32'(DEPTH_WORDS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_q   <= PW'(DEPTH_WORDS / 2);
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            rd_len_q  <= '0;
            wr_len_q  <= '0;
        end else begin
            if (split_ok) split_q <= cfg_wdata[PW-1:0];
            if (cfg_we && cfg_addr == RA_RD_ADDR) rd_addr_q <= cfg_wdata[ADDR_W-1:0];
            if (cfg_we && cfg_addr == RA_WR_ADDR) wr_addr_q <= cfg_wdata[ADDR_W-1:0];
            if (cfg_we && cfg_addr == RA_RD_LEN)  rd_len_q  <= cfg_wdata[LEN_W-1:0];
            if (cfg_we && cfg_addr == RA_WR_LEN)  wr_len_q  <= cfg_wdata[LEN_W-1:0];
        end
    end

    always_comb begin
        rd_lvl_w = ({1'b0, rd_cnt} + (CW+1)'(3)) >> 2;
        wr_lvl_w = ({1'b0, wr_cnt} + (CW+1)'(3)) >> 2;
        cfg_rdata = '0;
        unique case (cfg_addr)
            RA_RD_CTL: begin
                cfg_rdata[CTL_BUSY] = rd_busy;
                cfg_rdata[CTL_DONE] = rd_done;
            end
            RA_WR_CTL: begin
                cfg_rdata[CTL_BUSY] = wr_busy;
                cfg_rdata[CTL_DONE] = wr_done;
            end
            RA_RD_ADDR: cfg_rdata = 32'(rd_addr_q);
            RA_WR_ADDR: cfg_rdata = 32'(wr_addr_q);
            RA_RD_LEN:  cfg_rdata = 32'(rd_len_q);
            RA_WR_LEN:  cfg_rdata = 32'(wr_len_q);
            RA_LEVEL:   cfg_rdata = {16'(wr_lvl_w), 16'(rd_lvl_w)};
            RA_SPLIT:   cfg_rdata = 32'(split_q);
            default:    cfg_rdata = '0;
        endcase
    end

    // ------------------------------------------------------------------
    // per-direction sequencers
    // ------------------------------------------------------------------
    ixb_xfer_fsm #(.LEN_W(LEN_W)) u_rd_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (rd_ctl_we && cfg_wdata[CTL_START]),
        .cancel_req (rd_ctl_we && cfg_wdata[CTL_CANCEL]),
        .done_clr   (rd_ctl_we && cfg_wdata[CTL_DONE]),
        .len_in     (rd_len_q),
        .step       (rd_push),
        .busy       (rd_busy),
        .done       (rd_done),
        .launch     (rd_launch),
        .abort      (rd_abort),
        .left       (eng_rd_left)
    );

    ixb_xfer_fsm #(.LEN_W(LEN_W)) u_wr_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (wr_ctl_we && cfg_wdata[CTL_START]),
        .cancel_req (wr_ctl_we && cfg_wdata[CTL_CANCEL]),
        .done_clr   (wr_ctl_we && cfg_wdata[CTL_DONE]),
        .len_in     (wr_len_q),
        .step       (wr_pop),
        .busy       (wr_busy),
        .done       (wr_done),
        .launch     (wr_launch),
        .abort      (wr_abort),
        .left       (eng_wr_left)
    );

    assign rd_flush = rd_launch || rd_abort || split_ok;
    assign wr_flush = wr_launch || wr_abort || split_ok;

    // ------------------------------------------------------------------
    // partitions
    // ------------------------------------------------------------------
    assign rd_size = CW'({split_q, 2'b00});
    assign wr_size = CW'(NB) - rd_size;

    ixb_ring #(.SPAN(NB), .LANES(LANES), .CW(CW), .LW(LW)) u_rd_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rd_flush),
        .size    (rd_size),
        .push_n  (rd_push_n),
        .pop_n   (rd_pop_n),
        .cnt     (rd_cnt),
        .space   (rd_space),
        .wr_lane (rd_wl),
        .rd_lane (rd_rl)
    );

    ixb_ring #(.SPAN(NB), .LANES(LANES), .CW(CW), .LW(LW)) u_wr_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (wr_flush),
        .size    (wr_size),
        .push_n  (wr_push_n),
        .pop_n   (wr_pop_n),
        .cnt     (wr_cnt),
        .space   (wr_space),
        .wr_lane (wr_wl),
        .rd_lane (wr_rl)
    );

    // ------------------------------------------------------------------
    // host window and engine handshakes
    // ------------------------------------------------------------------
    always_comb begin
        if (host_word) wr_req_n = (host_left_q >= LEN_W'(4)) ? LW'(4) : LW'(host_left_q);
        else           wr_req_n = (host_left_q != '0) ? LW'(1) : LW'(0);
        rd_ok = host_word ? (rd_cnt >= CW'(4)) : (rd_cnt != '0);
        wr_ok = wr_busy && (wr_req_n != '0) && (wr_space >= CW'(wr_req_n));
        host_ack = host_req && (host_we ? wr_ok : rd_ok);
    end

    assign eng_rd_ready = rd_busy && (rd_space != '0);
    assign rd_push      = eng_rd_valid && eng_rd_ready;
    assign eng_wr_valid = wr_busy && (wr_cnt != '0);
    assign wr_pop       = eng_wr_valid && eng_wr_ready;

    assign rd_push_n = rd_push ? LW'(1) : LW'(0);
    assign rd_pop_n  = (host_ack && !host_we) ? (host_word ? LW'(4) : LW'(1)) : LW'(0);
    assign wr_push_n = (host_ack && host_we) ? wr_req_n : LW'(0);
    assign wr_pop_n  = wr_pop ? LW'(1) : LW'(0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          host_left_q <= '0;
        else if (wr_launch)  host_left_q <= wr_len_q;
        else if (wr_abort)   host_left_q <= '0;
        else                 host_left_q <= host_left_q - LEN_W'(wr_push_n);
    end

    // ------------------------------------------------------------------
    // shared byte store
    // ------------------------------------------------------------------
    for (genvar i = 0; i < LANES; i++) begin : g_addr
        assign wr_wa[i] = rd_size + wr_wl[i];
        assign rd_b[i]  = mem[rd_rl[i][BAW-1:0]];
    end
    assign wr_ra = rd_size + wr_rl[0];

    always_ff @(posedge clk) begin
        if (rd_push) mem[rd_wl[0][BAW-1:0]] <= eng_rd_byte;
        for (int i = 0; i < LANES; i++) begin
            if (LW'(i) < wr_push_n) mem[wr_wa[i][BAW-1:0]] <= host_wdata[8*i +: 8];
        end
    end

    assign host_rdata  = host_word ? {rd_b[3], rd_b[2], rd_b[1], rd_b[0]} : {24'd0, rd_b[0]};
    assign eng_wr_byte = mem[wr_ra[BAW-1:0]];
    assign eng_rd_busy = rd_busy;
    assign eng_wr_busy = wr_busy;
    assign eng_rd_addr = rd_addr_q;
    assign eng_wr_addr = wr_addr_q;

endmodule

// File: rtl/ixb_checker.sv
module ixb_checker
    import ixb_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_addr,
    input logic             cancel_bit,
    input logic             host_ack,
    input logic             host_we,
    input logic             eng_rd_valid,
    input logic             eng_rd_ready,
    input logic             eng_rd_busy,
    input logic [LEN_W-1:0] eng_rd_left,
    input logic             eng_wr_busy,
    input logic             rd_done,
    input logic             wr_done,
    input logic [CW-1:0]    rd_cnt,
    input logic [CW-1:0]    wr_cnt,
    input logic [CW-1:0]    rd_size,
    input logic [CW-1:0]    wr_size
);

    logic rd_cancel_w;
    assign rd_cancel_w = cfg_we && (cfg_addr == RA_RD_CTL) && cancel_bit;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt <= rd_size) && (wr_cnt <= wr_size));

    p_full_stalls_engine_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt == rd_size) |-> !eng_rd_ready);

    p_last_byte_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rd_busy && eng_rd_valid && eng_rd_ready && eng_rd_left == LEN_W'(1) && !rd_cancel_w)
        |=> (!eng_rd_busy && rd_done));

    p_left_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rd_busy && eng_rd_valid && eng_rd_ready && eng_rd_left > LEN_W'(1) && !rd_cancel_w)
        |=> (eng_rd_left == $past(eng_rd_left) - LEN_W'(1)));

    p_cancel_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cancel_w && eng_rd_busy) |=> (!eng_rd_busy && !rd_done && rd_cnt == '0));

    p_write_done_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_done) |-> (wr_cnt == '0));

    p_read_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !host_we) |-> (rd_cnt != '0));

    p_write_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_we) |-> eng_wr_busy);

endmodule

bind ixb_buffer_ctrl ixb_checker #(.LEN_W(LEN_W), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cancel_bit   (cfg_wdata[1]),
    .host_ack     (host_ack),
    .host_we      (host_we),
    .eng_rd_valid (eng_rd_valid),
    .eng_rd_ready (eng_rd_ready),
    .eng_rd_busy  (eng_rd_busy),
    .eng_rd_left  (eng_rd_left),
    .eng_wr_busy  (eng_wr_busy),
    .rd_done      (rd_done),
    .wr_done      (wr_done),
    .rd_cnt       (rd_cnt),
    .wr_cnt       (wr_cnt),
    .rd_size      (rd_size),
    .wr_size      (wr_size)
);

// File: tb/sim_ixb_buffer_ctrl.sv
module sim_ixb_buffer_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    localparam logic [31:0] RD_VEC [4] = '{32'h44332211, 32'hDEADBEEF, 32'h00FF7F80, 32'hA5C30001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        host_req = 1'b0, host_we = 1'b0, host_word = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic        eng_rd_valid = 1'b0;
    logic [7:0]  eng_rd_byte = '0;
    logic        eng_rd_ready, eng_rd_busy;
    logic [31:0] eng_rd_addr;
    logic [15:0] eng_rd_left;
    logic        eng_wr_ready = 1'b0;
    logic        eng_wr_valid;
    logic [7:0]  eng_wr_byte;
    logic        eng_wr_busy;
    logic [31:0] eng_wr_addr;
    logic [15:0] eng_wr_left;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ixb_buffer_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic push_try(input logic [7:0] b, output logic acc);
        @(negedge clk);
        eng_rd_valid = 1'b1; eng_rd_byte = b;
        #1 acc = eng_rd_ready;
        @(negedge clk);
        eng_rd_valid = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        logic acc;
        push_try(b, acc);
        chk("R4 engine byte accepted", 32'(acc), 32'd1);
    endtask

    task automatic host_rd(input logic word, output logic [31:0] d, output logic ack);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_word = word;
        #1 ack = host_ack; d = host_rdata;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic host_wr(input logic word, input logic [31:0] d, output logic ack);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_word = word; host_wdata = d;
        #1 ack = host_ack;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic pop(output logic v, output logic [7:0] b);
        @(negedge clk);
        eng_wr_ready = 1'b1;
        #1 v = eng_wr_valid; b = eng_wr_byte;
        @(negedge clk);
        eng_wr_ready = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        a, v;
        logic [7:0]  b;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_rd(3'd0, d); chk("R1 read ctl", d, 32'h0);
        cfg_rd(3'd3, d); chk("R1 write ctl", d, 32'h0);
        cfg_rd(3'd6, d); chk("R1 level", d, 32'h0);
        cfg_rd(3'd7, d); chk("R1 split", d, 32'd8);
        chk("R1 ready/valid", {eng_rd_ready, eng_wr_valid}, 32'h0);

        // R12 register map and address outputs
        cfg_wr(3'd1, 32'h0000_1000);
        cfg_rd(3'd1, d); chk("R12 read addr", d, 32'h1000);
        chk("R12 eng_rd_addr", eng_rd_addr, 32'h1000);

        // table walk: whole-word reads
        for (int k = 0; k < 4; k++) begin
            cfg_wr(3'd2, 32'd4);
            cfg_rd(3'd2, d); chk("R12 read count", d, 32'd4);
            cfg_wr(3'd0, 32'h1);
            cfg_rd(3'd0, d); chk("R2 in-progress after start", d, 32'h4);
            chk("R5 left loaded", 32'(eng_rd_left), 32'd4);
            for (int j = 0; j < 4; j++) push(RD_VEC[k][8*j +: 8]);
            cfg_rd(3'd0, d); chk("R5 done with busy clear", d, 32'h20);
            host_rd(1'b1, d, a);
            chk("R4 word read ack", 32'(a), 32'd1);
            chk("R3 word order", d, RD_VEC[k]);
            cfg_wr(3'd0, 32'h20);
            cfg_rd(3'd0, d); chk("R6 done cleared", d, 32'h0);
        end

        // R3/R4/R10 partial tail
        cfg_wr(3'd2, 32'd6);
        cfg_wr(3'd0, 32'h1);
        push(8'hA0); push(8'hA1); push(8'hA2);
        chk("R5 left after 3", 32'(eng_rd_left), 32'd3);
        host_rd(1'b1, d, a); chk("R4 word stall with 3 bytes", 32'(a), 32'd0);
        cfg_rd(3'd6, d); chk("R10 read level ceil", d, 32'h1);
        host_rd(1'b0, d, a); chk("R3 byte read ack", 32'(a), 32'd1);
        chk("R3 byte read data", d, 32'hA0);
        push(8'hA3); push(8'hA4); push(8'hA5);
        host_rd(1'b1, d, a); chk("R3 word after byte", d, 32'hA4A3A2A1);
        host_rd(1'b0, d, a); chk("R3 tail byte", d, 32'hA5);
        host_rd(1'b0, d, a); chk("R4 empty byte stall", 32'(a), 32'd0);
        cfg_rd(3'd0, d); chk("R5 tail done", d, 32'h20);

        // R4 full partition, R7 cancel
        cfg_wr(3'd2, 32'd40);
        cfg_wr(3'd0, 32'h1);
        n = 0;
        for (int j = 0; j < 32; j++) begin
            push_try(8'(j), a);
            if (a) n++;
        end
        chk("R4 32 bytes fit", 32'(n), 32'd32);
        push_try(8'hFF, a); chk("R4 full stalls engine", 32'(a), 32'd0);
        cfg_rd(3'd6, d); chk("R10 full level", d, 32'd8);
        chk("R5 left 8", 32'(eng_rd_left), 32'd8);
        cfg_wr(3'd0, 32'h2);
        cfg_rd(3'd0, d); chk("R7 cancel clears busy", d, 32'h0);
        cfg_rd(3'd6, d); chk("R7 cancel empties", d, 32'h0);
        cfg_wr(3'd0, 32'h2);
        cfg_rd(3'd0, d); chk("R7 idle cancel no effect", d, 32'h0);

        // R2 start while busy ignored; R6 zero write keeps done
        cfg_wr(3'd2, 32'd2);
        cfg_wr(3'd0, 32'h1);
        push(8'h5A);
        cfg_wr(3'd0, 32'h1);
        chk("R2 start while busy ignored", 32'(eng_rd_left), 32'd1);
        push(8'h5B);
        cfg_wr(3'd0, 32'h0);
        cfg_rd(3'd0, d); chk("R6 zero write keeps done", d, 32'h20);
        cfg_wr(3'd2, 32'd0);
        cfg_wr(3'd0, 32'h1);
        cfg_rd(3'd0, d); chk("R5 zero count goes done", d, 32'h20);
        cfg_rd(3'd6, d); chk("R2 start empties buffer", d, 32'h0);
        cfg_wr(3'd0, 32'h20);

        // R8/R9 write path
        host_wr(1'b1, 32'h12345678, a); chk("R8 idle write stalls", 32'(a), 32'd0);
        cfg_wr(3'd4, 32'h0000_2000);
        chk("R12 eng_wr_addr", eng_wr_addr, 32'h2000);
        cfg_wr(3'd5, 32'd6);
        cfg_wr(3'd3, 32'h1);
        chk("R5 write left", 32'(eng_wr_left), 32'd6);
        host_wr(1'b1, 32'h44332211, a); chk("R8 word write ack", 32'(a), 32'd1);
        cfg_rd(3'd6, d); chk("R10 write level", d, 32'h0001_0000);
        host_wr(1'b1, 32'h88776655, a); chk("R8 short word ack", 32'(a), 32'd1);
        cfg_rd(3'd6, d); chk("R8 only owed bytes stored", d, 32'h0002_0000);
        host_wr(1'b0, 32'h99, a); chk("R8 nothing owed stalls", 32'(a), 32'd0);
        for (int j = 0; j < 6; j++) begin
            pop(v, b);
            chk("R8 write byte order", {23'd0, v, b}, {23'd0, 1'b1, 8'(8'h11 * (j + 1))});
        end
        cfg_rd(3'd3, d); chk("R9 write done", d, 32'h20);
        cfg_rd(3'd6, d); chk("R9 level zero at done", d, 32'h0);
        pop(v, b); chk("R9 no byte after done", 32'(v), 32'd0);
        cfg_wr(3'd3, 32'h20);

        // R8 write partition full
        cfg_wr(3'd5, 32'd40);
        cfg_wr(3'd3, 32'h1);
        n = 0;
        for (int j = 0; j < 8; j++) begin
            host_wr(1'b1, 32'(j), a);
            if (a) n++;
        end
        chk("R8 eight words fit", 32'(n), 32'd8);
        host_wr(1'b1, 32'hFFFF, a); chk("R8 full partition stalls", 32'(a), 32'd0);
        cfg_rd(3'd6, d); chk("R10 write full level", d, 32'h0008_0000);
        cfg_wr(3'd3, 32'h2);
        cfg_rd(3'd6, d); chk("R7 write cancel empties", d, 32'h0);

        // R11 split
        cfg_wr(3'd7, 32'd4);
        cfg_rd(3'd7, d); chk("R11 split taken", d, 32'd4);
        cfg_wr(3'd2, 32'd20);
        cfg_wr(3'd0, 32'h1);
        n = 0;
        for (int j = 0; j < 16; j++) begin
            push_try(8'(j), a);
            if (a) n++;
        end
        chk("R11 read side 16 bytes", 32'(n), 32'd16);
        push_try(8'h00, a); chk("R11 read side full", 32'(a), 32'd0);
        cfg_wr(3'd7, 32'd6);
        cfg_rd(3'd7, d); chk("R11 split ignored while busy", d, 32'd4);
        cfg_wr(3'd0, 32'h2);
        cfg_wr(3'd7, 32'd0);
        cfg_rd(3'd7, d); chk("R11 split zero ignored", d, 32'd4);
        cfg_wr(3'd7, 32'd16);
        cfg_rd(3'd7, d); chk("R11 split too large ignored", d, 32'd4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule